// File: doc/BRIEF.md
# PCI DMA Window Address Translator

This block maps an address seen on the PCI bus onto a system memory address for DMA traffic. It does this through four programmable windows. Each window holds three 64-bit words: a base word that also carries an enable bit and a scatter-gather mode bit, a size mask, and a target base. The size mask decides which of address bits 30:20 are compared against the base and which are passed through. The low 20 bits always pass through, so the smallest window is 1 MB.

Software programs the twelve words through a simple word-addressed register port. The bus side presents an address every cycle. One clock edge later the block returns the translated address, a hit flag and an error flag. The windows are searched in index order. The first window that is enabled and matches decides the result. A window set to scatter-gather mode is not translated here. It raises the error flag instead.

Top module: `pci_dma_window_xlate`

## Requirements
- R1: While reset is high, every window word is cleared to zero. After reset, all twelve words read back as zero, and `xl_hit`, `xl_err` and `xl_addr` are zero.
- R2: A write with `reg_we` high stores `reg_wdata` into the word chosen by `reg_addr`. The word index is `reg_addr[3:2]`. `reg_addr[1:0]` selects the kind: 0 is the base, 1 is the size mask, 2 is the target base. `reg_addr[4]` must be 0. The value read at `reg_addr` appears on `reg_rdata` one clock edge after the address is presented.
- R3: A window matches a bus address when, on every bit position 30:20 whose size-mask bit is 0, the bus address equals the window base. Bits above 30 and below 20 take no part in the compare.
- R4: Base bit 0 enables the window. A window that matches but is disabled is skipped, and the search goes on to the next index.
- R5: On a hit, the offset mask is the size-mask bits 30:20 together with bits 19:0. The output takes the bits inside the offset mask from the bus address and all other bits from the target base.
- R6: Windows are searched from index 0 up to index 3, and the lowest-indexed enabled matching window decides the result.
- R7: If the deciding window has base bit 1 set (scatter-gather mode), the outputs are `xl_err` = 1, `xl_hit` = 0 and `xl_addr` = 0. `xl_hit` and `xl_err` are never high together.
- R8: When no enabled window matches, all three outputs are zero. A direct-mode hit always sets `xl_hit`, even when the translated address is zero.
- R9: Addresses with kind 3, or with `reg_addr[4]` set, read as zero, and writes to them change no window word.
- R10: The result for `lk_addr` appears on the outputs one clock edge later. A lookup made in the same cycle as a register write uses the window values from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Word address of the register |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data, registered |
| lk_addr | input | 64 | PCI bus address to translate |
| xl_addr | output | 64 | Translated system address, registered |
| xl_hit | output | 1 | A direct-mode window produced `xl_addr` |
| xl_err | output | 1 | The deciding window is in scatter-gather mode |

## Verification
Both the read data and the translation result are due exactly one rising edge after their inputs are presented. The bench drives every stimulus on a falling edge and samples the matching result on the next falling edge, half a period after the edge that registers it. The same-cycle case is checked on two consecutive falling edges: the first shows the result from the old window values, and the second shows the result from the new ones. Register readback uses the same one-edge rule.

// File: rtl/pdt_pkg.sv
package pdt_pkg;

    localparam int unsigned WORD_W    = 64;
    localparam int unsigned NUM_WIN   = 4;
    localparam int unsigned WIN_IDX_W = $clog2(NUM_WIN);
    localparam int unsigned KIND_W    = 2;
    localparam int unsigned REG_AW    = 5;
    localparam int unsigned CMP_LO    = 20;
    localparam int unsigned CMP_HI    = 30;
    localparam int unsigned BIT_EN    = 0;
    localparam int unsigned BIT_SG    = 1;

    typedef enum logic [KIND_W-1:0] {
        RK_BASE   = 2'd0,
        RK_SIZE   = 2'd1,
        RK_TARGET = 2'd2,
        RK_NONE   = 2'd3
    } reg_kind_e;

    typedef struct packed {
        logic [WORD_W-1:0] base;
        logic [WORD_W-1:0] size;
        logic [WORD_W-1:0] target;
    } win_cfg_t;

    typedef struct packed {
        logic              hit;
        logic              err;
        logic [WORD_W-1:0] addr;
    } xl_res_t;

    function automatic logic reg_is_mapped(input logic [REG_AW-1:0] a);
        return (a[REG_AW-1:KIND_W+WIN_IDX_W] == '0) &&
               (reg_kind_e'(a[KIND_W-1:0]) != RK_NONE);
    endfunction

    function automatic logic [WORD_W-1:0] cmp_mask(input logic [WORD_W-1:0] size);
        logic [WORD_W-1:0] m;
        m = '0;
        m[CMP_HI:CMP_LO] = ~size[CMP_HI:CMP_LO];
        return m;
    endfunction

    function automatic logic [WORD_W-1:0] off_mask(input logic [WORD_W-1:0] size);
        logic [WORD_W-1:0] m;
        m = '0;
        m[CMP_HI:CMP_LO]   = size[CMP_HI:CMP_LO];
        m[CMP_LO-1:0]      = '1;
        return m;
    endfunction

endpackage

// File: rtl/pdt_regfile.sv
module pdt_regfile
    import pdt_pkg::*;
#(
    parameter int unsigned N_WIN = NUM_WIN,
    parameter int unsigned AW    = REG_AW
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          we,
    input  logic [AW-1:0]                 addr,
    input  logic [WORD_W-1:0]             wdata,
    output logic [WORD_W-1:0]             rdata,
    output win_cfg_t [N_WIN-1:0]          cfg
);
    localparam int unsigned IDX_W = (N_WIN > 1) ? $clog2(N_WIN) : 1;

    logic              mapped;
    logic [IDX_W-1:0]  idx;
    reg_kind_e         kind;

    assign mapped = reg_is_mapped(addr);
    assign idx    = addr[KIND_W +: IDX_W];
    assign kind   = reg_kind_e'(addr[KIND_W-1:0]);

    for (genvar w = 0; w < N_WIN; w++) begin : g_win
        logic sel;
        assign sel = we && mapped && (idx == IDX_W'(w));
        always_ff @(posedge clk) begin
            if (rst) begin
                cfg[w] <= '0;
            end else if (sel) begin
                case (kind)
                    RK_BASE:   cfg[w].base   <= wdata;
                    RK_SIZE:   cfg[w].size   <= wdata;
                    RK_TARGET: cfg[w].target <= wdata;
                    default:   ;
                endcase
            end
        end
    end

    logic [WORD_W-1:0] rd_next;
    always_comb begin
        rd_next = '0;
        if (mapped) begin
            case (kind)
                RK_BASE:   rd_next = cfg[idx].base;
                RK_SIZE:   rd_next = cfg[idx].size;
                RK_TARGET: rd_next = cfg[idx].target;
                default:   rd_next = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rdata <= '0;
        else     rdata <= rd_next;
    end
endmodule

// File: rtl/pdt_window_eval.sv
module pdt_window_eval
    import pdt_pkg::*;
(
    input  win_cfg_t          cfg,
    input  logic [WORD_W-1:0] bus,
    output logic              cand,
    output logic              sg,
    output logic [WORD_W-1:0] xaddr
);
    logic              match;
    logic [WORD_W-1:0] off;

    assign match = ((bus ^ cfg.base) & cmp_mask(cfg.size)) == '0;
    assign cand  = match && cfg.base[BIT_EN];
    assign sg    = cfg.base[BIT_SG];
    assign off   = off_mask(cfg.size);
    assign xaddr = (cfg.target & ~off) | (bus & off);
endmodule

// File: rtl/pdt_prio_pick.sv
module pdt_prio_pick
    import pdt_pkg::*;
#(
    parameter int unsigned N_WIN = NUM_WIN
) (
    input  logic [N_WIN-1:0]              cand,
    input  logic [N_WIN-1:0]              sg,
    input  logic [N_WIN-1:0][WORD_W-1:0]  xaddr,
    output xl_res_t                       res
);
    always_comb begin
        logic found;
        found = 1'b0;
        res   = '0;
        for (int i = 0; i < int'(N_WIN); i++) begin
            if (!found && cand[i]) begin
                found = 1'b1;
                if (sg[i]) begin
                    res.err = 1'b1;
                end else begin
                    res.hit  = 1'b1;
                    res.addr = xaddr[i];
                end
            end
        end
    end
endmodule

// File: rtl/pci_dma_window_xlate.sv
module pci_dma_window_xlate
    import pdt_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_we,
    input  logic [REG_AW-1:0]   reg_addr,
    input  logic [WORD_W-1:0]   reg_wdata,
    output logic [WORD_W-1:0]   reg_rdata,
    input  logic [WORD_W-1:0]   lk_addr,
    output logic [WORD_W-1:0]   xl_addr,
    output logic                xl_hit,
    output logic                xl_err
);
    win_cfg_t [NUM_WIN-1:0]             cfg;
    logic [NUM_WIN-1:0]                 cand;
    logic [NUM_WIN-1:0]                 sg;
    logic [NUM_WIN-1:0][WORD_W-1:0]     xaddr;
    xl_res_t                            res_c;
    xl_res_t                            res_q;

    pdt_regfile #(.N_WIN(NUM_WIN), .AW(REG_AW)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (reg_we),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .cfg   (cfg)
    );

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_eval
        pdt_window_eval u_eval (
            .cfg   (cfg[w]),
            .bus   (lk_addr),
            .cand  (cand[w]),
            .sg    (sg[w]),
            .xaddr (xaddr[w])
        );
    end

    pdt_prio_pick #(.N_WIN(NUM_WIN)) u_pick (
        .cand  (cand),
        .sg    (sg),
        .xaddr (xaddr),
        .res   (res_c)
    );

    always_ff @(posedge clk) begin
        if (rst) res_q <= '0;
        else     res_q <= res_c;
    end

    assign xl_addr = res_q.addr;
    assign xl_hit  = res_q.hit;
    assign xl_err  = res_q.err;
endmodule

// File: rtl/pdt_chk.sv
module pdt_chk
    import pdt_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic [REG_AW-1:0]   reg_addr,
    input logic [WORD_W-1:0]   reg_rdata,
    input logic [WORD_W-1:0]   lk_addr,
    input logic [WORD_W-1:0]   xl_addr,
    input logic                xl_hit,
    input logic                xl_err
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> (!xl_hit && !xl_err && xl_addr == '0 && reg_rdata == '0));

    // R7
    hit_err_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(xl_hit && xl_err));

    // R8
    miss_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !xl_hit |-> xl_addr == '0);

    // R5
    low_pass_chk: assert property (@(posedge clk) disable iff (rst)
        xl_hit |-> xl_addr[CMP_LO-1:0] == $past(lk_addr[CMP_LO-1:0]));

    // R9
    unmapped_rd_chk: assert property (@(posedge clk) disable iff (rst)
        !reg_is_mapped($past(reg_addr)) |-> reg_rdata == '0);
endmodule

bind pci_dma_window_xlate pdt_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .lk_addr   (lk_addr),
    .xl_addr   (xl_addr),
    .xl_hit    (xl_hit),
    .xl_err    (xl_err)
);

// File: tb/pci_dma_window_xlate_tb.sv
module pci_dma_window_xlate_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic [63:0] lk_addr = '0;
    logic [63:0] xl_addr;
    logic        xl_hit;
    logic        xl_err;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    pci_dma_window_xlate dut_i (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_addr(lk_addr),
        .xl_addr(xl_addr), .xl_hit(xl_hit), .xl_err(xl_err)
    );

    // Vector table: bus address, expected address, expected {hit, err}
    localparam int NV = 9;
    localparam logic [63:0] V_BUS [NV] = '{
        64'h0000_0000_2001_2345, 64'h0000_0000_2011_2345, 64'h0000_0000_200F_FFFF,
        64'h0000_0000_2010_0000, 64'h0000_0000_2020_0000, 64'hFFFF_0000_6012_3456,
        64'h0000_0000_1000_0000, 64'h0000_0000_6030_0001, 64'h0000_0000_6040_0000};
    localparam logic [63:0] V_EXP [NV] = '{
        64'h0, 64'h0000_0000_8011_2345, 64'h0,
        64'h0000_0000_8010_0000, 64'h0, 64'h0000_00AB_C012_3456,
        64'h0, 64'h0000_00AB_C030_0001, 64'h0};
    localparam logic [1:0] V_FLG [NV] = '{
        2'b01, 2'b10, 2'b01, 2'b10, 2'b00, 2'b10, 2'b00, 2'b10, 2'b00};

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [4:0] a, input logic [63:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_rd(input string req, input logic [4:0] a, input logic [63:0] exp);
        @(negedge clk);
        reg_addr = a;
        @(negedge clk);
        chk(req, reg_rdata, exp);
    endtask

    task automatic look(input string req, input logic [63:0] bus,
                        input logic [63:0] exp, input logic [1:0] flg);
        @(negedge clk);
        lk_addr = bus;
        @(negedge clk);
        chk(req, xl_addr, exp);
        chk(req, {62'b0, xl_hit, xl_err}, {62'b0, flg});
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk("R1 outputs", {xl_addr[61:0], xl_hit, xl_err}, 64'h0);
        for (int w = 0; w < 4; w++)
            for (int k = 0; k < 3; k++)
                reg_rd("R1 word", 5'(w * 4 + k), 64'h0);

        // Configure: W0 disabled 0x600 region, W1 SG 1MB at 0x200,
        // W2 direct 2MB at 0x200, W3 direct 4MB at 0x600
        reg_wr(5'd0,  64'h0000_0000_6000_0000);
        reg_wr(5'd1,  64'h0000_0000_0030_0000);
        reg_wr(5'd2,  64'h0000_0000_DEAD_0000);
        reg_wr(5'd4,  64'h0000_0000_2000_0003);
        reg_wr(5'd5,  64'h0);
        reg_wr(5'd8,  64'h0000_0000_2000_0001);
        reg_wr(5'd9,  64'h0000_0000_0010_0000);
        reg_wr(5'd10, 64'h0000_0000_8000_0000);
        reg_wr(5'd12, 64'h0000_0000_6000_0001);
        reg_wr(5'd13, 64'h0000_0000_0030_0000);
        reg_wr(5'd14, 64'h0000_00AB_C000_0000);

        // R2: readback
        reg_rd("R2 W1 base", 5'd4, 64'h0000_0000_2000_0003);
        reg_rd("R2 W3 target", 5'd14, 64'h0000_00AB_C000_0000);
        reg_rd("R2 W2 size", 5'd9, 64'h0000_0000_0010_0000);

        // R3 R4 R5 R6 R7 R8: vector walk
        for (int i = 0; i < NV; i++)
            look("R3-vector R4 R5 R6 R7 R8", V_BUS[i], V_EXP[i], V_FLG[i]);

        // R9: unmapped addresses
        reg_wr(5'd3, 64'h1234);
        reg_rd("R9 kind3 read", 5'd3, 64'h0);
        reg_wr(5'd16, 64'hFFFF_FFFF);
        reg_rd("R9 alias W0 base", 5'd0, 64'h0000_0000_6000_0000);
        reg_rd("R9 high read", 5'd16, 64'h0);
        look("R9 lookup unchanged", 64'h2011_2345, 64'h8011_2345, 2'b10);

        // R10: lookup in same cycle as write uses old values
        @(negedge clk);
        lk_addr = 64'h2011_2345;
        reg_we = 1'b1; reg_addr = 5'd8; reg_wdata = 64'h2000_0000;
        @(negedge clk);
        reg_we = 1'b0;
        chk("R10 old values addr", xl_addr, 64'h8011_2345);
        chk("R10 old values hit", {63'b0, xl_hit}, 64'h1);
        @(negedge clk);
        chk("R10 new values addr", xl_addr, 64'h0);
        chk("R10 new values hit", {63'b0, xl_hit}, 64'h0);

        // R8: zero translated address still reports hit
        reg_wr(5'd14, 64'h0);
        look("R8 zero-result hit", 64'h6000_0000, 64'h0, 2'b10);

        // R6: W1 (SG) shadows W2 again when W2 re-enabled
        reg_wr(5'd8, 64'h2000_0001);
        look("R6 priority", 64'h2000_0000, 64'h0, 2'b01);

        // R1: reset clears words again
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        reg_rd("R1 re-reset", 5'd12, 64'h0);
        look("R1 re-reset lookup", 64'h6000_0000, 64'h0, 2'b00);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule